// File: doc/BRIEF.md
# Channel Memory Window Allocator

This block sits between a bank of signal-timing channels and one shared word RAM. The RAM is built from equal blocks, one per channel, and by default each channel owns the block that matches its number. A per-channel block-count setting lets a channel spill into the blocks of the channels numbered after it. The region runs past the top of the RAM and wraps back to word 0. The block turns a channel-relative word index from that channel's transmit or receive engine into a physical RAM word address. It publishes every channel's window bounds as plain outputs.

Each channel also has an owner bit that gives its region to either the transmit engine or the receive engine. An access from the engine that does not own the region is refused: it can never produce a RAM write enable. It also latches a per-channel error interrupt, which stays high until a write-one clear. An index that falls past the end of the channel's window is reported as out of range and gives no address.

Top module: `chmem_window_alloc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid`, `rsp_ok`, `ram_we` and every bit of `err_irq` are 0.
- R2: `start_addr` field n (bits n*ADDR_W and up) always equals the word address n*64 with default parameters. It depends on nothing else.
- R3: `end_addr` field n equals (64*n + 64*S) mod 512. S is the effective block count: a `cfg_size` field of 0 counts as 1, and a value above 8 (the block total) counts as 8. The value is exclusive, so a window of all 8 blocks has end equal to start.
- R4: A request sampled at a clock edge gives its response on the outputs right after that same edge. For an in-range access by the owning engine, the response is `rsp_valid`=1, `rsp_ok`=1, `rsp_oor`=0, `rsp_viol`=0 and `rsp_addr` = (64*req_ch + req_idx) mod 512.
- R5: `cfg_owner` bit n = 0 gives channel n to the transmit engine (`req_rx`=0), and 1 gives it to the receive engine (`req_rx`=1). A request from the other engine gives `rsp_viol`=1 and `rsp_ok`=0. It also sets `err_irq` bit n at the same edge as that response.
- R6: `ram_we` is 1 only with a permitted, in-range write (`req_write`=1), in the same cycle as its response. Reads and violating writes leave it at 0.
- R7: A `req_idx` of 64*S or more gives `rsp_oor`=1, `rsp_ok`=0, `rsp_addr`=0 and `ram_we`=0. By itself it does not set `err_irq`.
- R8: An `err_irq` bit stays at 1 until its `err_clr` bit is 1 at a clock edge, and it reads 0 after that edge. If a new violation on that channel lands at the same edge as the clear, the bit stays 1.
- R9: A violation on channel n changes no `err_irq` bit other than bit n.
- R10: In a cycle with no request (`req_valid`=0), the response after the next edge has `rsp_valid`, `rsp_ok`, `rsp_oor`, `rsp_viol` and `ram_we` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cfg_size | input | NUM_CH*SIZE_W | Block count per channel, field n at bits n*SIZE_W |
| cfg_owner | input | NUM_CH | Owner per channel: 0 transmit engine, 1 receive engine |
| err_clr | input | NUM_CH | Write-one clear of the error flags |
| req_valid | input | 1 | An access request is present |
| req_ch | input | CH_W | Channel of the request |
| req_rx | input | 1 | Requester: 0 transmit engine, 1 receive engine |
| req_write | input | 1 | Request is a write |
| req_idx | input | ADDR_W | Channel-relative word index |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | ADDR_W | Physical RAM word address, 0 when out of range |
| rsp_ok | output | 1 | Access in range and permitted |
| rsp_oor | output | 1 | Index beyond the channel window |
| rsp_viol | output | 1 | Ownership violation |
| ram_we | output | 1 | Write enable toward the RAM |
| err_irq | output | NUM_CH | Sticky per-channel error interrupt |
| start_addr | output | NUM_CH*ADDR_W | First word of each channel window |
| end_addr | output | NUM_CH*ADDR_W | Exclusive end word of each window, wrapped |

## Verification
The window bounds are combinational from `cfg_size`. The bench reads them one time unit after it changes the configuration, with no clock edge in between. Responses and error flags take one register stage. Each request is driven at a falling edge, and its response and `err_irq` are sampled one time unit after the next rising edge, before the next edge can move them. A clear is checked in the same way, one edge after it is driven, with an idle cycle placed between the violation and the clear so the flag's hold time is seen.

// File: rtl/chmem_pkg.sv
package chmem_pkg;

  localparam int unsigned DEF_NUM_CH    = 8;
  localparam int unsigned DEF_BLK_WORDS = 64;
  localparam int unsigned DEF_SIZE_W    = 4;

  // Effective number of blocks taken by a channel: zero means one block,
  // anything above the block total is held at the block total.
  function automatic int unsigned eff_blocks(input int unsigned raw,
                                             input int unsigned max_blk);
    if (raw == 0)            return 1;
    else if (raw > max_blk)  return max_blk;
    else                     return raw;
  endfunction

endpackage

// File: rtl/chmem_win_calc.sv
module chmem_win_calc #(
  parameter int unsigned CH_IDX    = 0,
  parameter int unsigned BLK_WORDS = 64,
  parameter int unsigned NUM_BLK   = 8,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned ADDR_W    = 9,
  localparam int unsigned LIM_W    = ADDR_W + 1
) (
  input  logic [SIZE_W-1:0] raw_size,
  output logic [ADDR_W-1:0] win_start,
  output logic [ADDR_W-1:0] win_end,
  output logic [LIM_W-1:0]  win_limit
);

  int unsigned eff;
  int unsigned span;
  logic [LIM_W-1:0] end_sum;

  always_comb begin
    eff       = chmem_pkg::eff_blocks(32'(raw_size), NUM_BLK);
    span      = eff * BLK_WORDS;
    win_limit = LIM_W'(span);
    win_start = ADDR_W'(CH_IDX * BLK_WORDS);
    // RAM depth is a power of two, so dropping the carry is the modulo.
    end_sum   = LIM_W'(CH_IDX * BLK_WORDS + span);
    win_end   = end_sum[ADDR_W-1:0];
  end

endmodule

// File: rtl/chmem_xlate.sv
module chmem_xlate #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CH_W   = 3
) (
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_ch,
  input  logic              req_rx,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_idx,
  input  logic [ADDR_W-1:0] start_a [NUM_CH],
  input  logic [ADDR_W:0]   limit_a [NUM_CH],
  input  logic [NUM_CH-1:0] owner,
  output logic              nx_valid,
  output logic [ADDR_W-1:0] nx_addr,
  output logic              nx_ok,
  output logic              nx_oor,
  output logic              nx_viol,
  output logic              nx_we,
  output logic [NUM_CH-1:0] nx_set
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   lim;
  logic              beyond;
  logic              wrong_eng;

  always_comb begin
    base      = start_a[req_ch];
    lim       = limit_a[req_ch];
    beyond    = ({1'b0, req_idx} >= lim);
    wrong_eng = (req_rx != owner[req_ch]);

    nx_valid  = req_valid;
    nx_oor    = req_valid & beyond;
    nx_viol   = req_valid & wrong_eng;
    nx_ok     = req_valid & ~beyond & ~wrong_eng;
    nx_addr   = (req_valid && !beyond) ? (base + req_idx) : '0;
    nx_we     = nx_ok & req_write;

    nx_set    = '0;
    if (nx_viol) nx_set[req_ch] = 1'b1;
  end

endmodule

// File: rtl/chmem_err_flags.sv
module chmem_err_flags #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] flags
);

  logic [NUM_CH-1:0] flags_d;

  // Set wins over a clear that lands at the same edge.
  always_comb begin
    flags_d = (flags & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

endmodule

// File: rtl/chmem_window_alloc.sv
module chmem_window_alloc #(
  parameter int unsigned NUM_CH    = chmem_pkg::DEF_NUM_CH,
  parameter int unsigned BLK_WORDS = chmem_pkg::DEF_BLK_WORDS,
  parameter int unsigned SIZE_W    = chmem_pkg::DEF_SIZE_W,
  localparam int unsigned RAM_WORDS = NUM_CH * BLK_WORDS,
  localparam int unsigned ADDR_W    = $clog2(RAM_WORDS),
  localparam int unsigned CH_W      = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*SIZE_W-1:0] cfg_size,
  input  logic [NUM_CH-1:0]        cfg_owner,
  input  logic [NUM_CH-1:0]        err_clr,
  input  logic                     req_valid,
  input  logic [CH_W-1:0]          req_ch,
  input  logic                     req_rx,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_idx,
  output logic                     rsp_valid,
  output logic [ADDR_W-1:0]        rsp_addr,
  output logic                     rsp_ok,
  output logic                     rsp_oor,
  output logic                     rsp_viol,
  output logic                     ram_we,
  output logic [NUM_CH-1:0]        err_irq,
  output logic [NUM_CH*ADDR_W-1:0] start_addr,
  output logic [NUM_CH*ADDR_W-1:0] end_addr
);

  logic [ADDR_W-1:0] start_a [NUM_CH];
  logic [ADDR_W-1:0] end_a   [NUM_CH];
  logic [ADDR_W:0]   limit_a [NUM_CH];

  // One window calculator per channel; bounds stay combinational.
  for (genvar n = 0; n < NUM_CH; n++) begin : g_win
    chmem_win_calc #(
      .CH_IDX    (n),
      .BLK_WORDS (BLK_WORDS),
      .NUM_BLK   (NUM_CH),
      .SIZE_W    (SIZE_W),
      .ADDR_W    (ADDR_W)
    ) u_win (
      .raw_size  (cfg_size[n*SIZE_W +: SIZE_W]),
      .win_start (start_a[n]),
      .win_end   (end_a[n]),
      .win_limit (limit_a[n])
    );
    assign start_addr[n*ADDR_W +: ADDR_W] = start_a[n];
    assign end_addr[n*ADDR_W +: ADDR_W]   = end_a[n];
  end

  logic              nx_valid;
  logic [ADDR_W-1:0] nx_addr;
  logic              nx_ok;
  logic              nx_oor;
  logic              nx_viol;
  logic              nx_we;
  logic [NUM_CH-1:0] nx_set;

  chmem_xlate #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CH_W   (CH_W)
  ) u_xlate (
    .req_valid (req_valid),
    .req_ch    (req_ch),
    .req_rx    (req_rx),
    .req_write (req_write),
    .req_idx   (req_idx),
    .start_a   (start_a),
    .limit_a   (limit_a),
    .owner     (cfg_owner),
    .nx_valid  (nx_valid),
    .nx_addr   (nx_addr),
    .nx_ok     (nx_ok),
    .nx_oor    (nx_oor),
    .nx_viol   (nx_viol),
    .nx_we     (nx_we),
    .nx_set    (nx_set)
  );

  chmem_err_flags #(
    .NUM_CH (NUM_CH)
  ) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (nx_set),
    .clr_vec (err_clr),
    .flags   (err_irq)
  );

  // Response register: one stage between request and result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_ok    <= 1'b0;
      rsp_oor   <= 1'b0;
      rsp_viol  <= 1'b0;
      ram_we    <= 1'b0;
    end else begin
      rsp_valid <= nx_valid;
      rsp_addr  <= nx_addr;
      rsp_ok    <= nx_ok;
      rsp_oor   <= nx_oor;
      rsp_viol  <= nx_viol;
      ram_we    <= nx_we;
    end
  end

endmodule

// File: rtl/chmem_window_alloc_chk.sv
module chmem_window_alloc_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned BLK_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CH_W-1:0]   req_ch,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_idx,
  input logic [NUM_CH-1:0] err_clr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_ok,
  input logic              rsp_oor,
  input logic              rsp_viol,
  input logic              ram_we,
  input logic [NUM_CH-1:0] err_irq
);

  // Windows start on block boundaries, so an accepted address keeps the
  // low bits of the index it came from.
  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> rsp_addr[BLK_W-1:0] == $past(req_idx[BLK_W-1:0]));

  p_ok_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (!rsp_viol && !rsp_oor && rsp_valid));

  p_viol_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_viol |-> err_irq[$past(req_ch)]);

  p_we_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (rsp_ok && $past(req_write)));

  p_oor_noaddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_oor |-> (!rsp_ok && rsp_addr == '0 && !ram_we));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !ram_we && !rsp_viol && !rsp_oor));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sticky
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_irq[i] && !err_clr[i]) |=> err_irq[i]);
  end

endmodule

bind chmem_window_alloc chmem_window_alloc_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .CH_W   (CH_W),
  .BLK_W  ($clog2(BLK_WORDS))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ch    (req_ch),
  .req_write (req_write),
  .req_idx   (req_idx),
  .err_clr   (err_clr),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_ok    (rsp_ok),
  .rsp_oor   (rsp_oor),
  .rsp_viol  (rsp_viol),
  .ram_we    (ram_we),
  .err_irq   (err_irq)
);

// File: tb/chmem_window_alloc_tb.sv
module chmem_window_alloc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 8;
  localparam int SIZE_W     = 4;
  localparam int ADDR_W     = 9;
  localparam int CH_W       = 3;

  logic                     clk;
  logic                     rst_n;
  logic [NUM_CH*SIZE_W-1:0] cfg_size;
  logic [NUM_CH-1:0]        cfg_owner;
  logic [NUM_CH-1:0]        err_clr;
  logic                     req_valid;
  logic [CH_W-1:0]          req_ch;
  logic                     req_rx;
  logic                     req_write;
  logic [ADDR_W-1:0]        req_idx;
  logic                     rsp_valid;
  logic [ADDR_W-1:0]        rsp_addr;
  logic                     rsp_ok;
  logic                     rsp_oor;
  logic                     rsp_viol;
  logic                     ram_we;
  logic [NUM_CH-1:0]        err_irq;
  logic [NUM_CH*ADDR_W-1:0] start_addr;
  logic [NUM_CH*ADDR_W-1:0] end_addr;

  int n_checks = 0;
  int n_errs   = 0;

  chmem_window_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_owner(cfg_owner),
    .err_clr(err_clr), .req_valid(req_valid), .req_ch(req_ch),
    .req_rx(req_rx), .req_write(req_write), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_ok(rsp_ok),
    .rsp_oor(rsp_oor), .rsp_viol(rsp_viol), .ram_we(ram_we),
    .err_irq(err_irq), .start_addr(start_addr), .end_addr(end_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_size(input int ch, input int val);
    cfg_size[ch*SIZE_W +: SIZE_W] = SIZE_W'(val);
  endtask

  function automatic int exp_end(input int ch, input int raw);
    int s;
    s = (raw == 0) ? 1 : ((raw > 8) ? 8 : raw);
    return (64*ch + 64*s) % 512;
  endfunction

  // Drive one cycle of inputs at a falling edge, let the rising edge take
  // them, then return just after it with the inputs idle again.
  task automatic cycle(input bit v, input int ch, input bit rx, input bit wr,
                       input int idx, input int clr);
    @(negedge clk);
    req_valid = v;
    req_ch    = CH_W'(ch);
    req_rx    = rx;
    req_write = wr;
    req_idx   = ADDR_W'(idx);
    err_clr   = NUM_CH'(clr);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_write = 1'b0;
    err_clr   = '0;
  endtask

  task automatic t_reset;
    check_eq("R1 rsp_valid", int'(rsp_valid), 0);
    check_eq("R1 rsp_ok",    int'(rsp_ok), 0);
    check_eq("R1 ram_we",    int'(ram_we), 0);
    check_eq("R1 err_irq",   int'(err_irq), 0);
  endtask

  task automatic t_default_map;
    @(negedge clk);
    for (int n = 0; n < NUM_CH; n++) set_size(n, 1);
    #1;
    for (int n = 0; n < NUM_CH; n++) begin
      check_eq($sformatf("R2 start ch%0d", n),
               int'(start_addr[n*ADDR_W +: ADDR_W]), 64*n);
      check_eq($sformatf("R3 end ch%0d", n),
               int'(end_addr[n*ADDR_W +: ADDR_W]), exp_end(n, 1));
    end
  endtask

  task automatic t_size_cfg;
    @(negedge clk);
    set_size(0, 0);
    set_size(1, 12);
    set_size(2, 3);
    set_size(6, 4);
    set_size(7, 2);
    #1;
    check_eq("R3 size0 as one",  int'(end_addr[0*ADDR_W +: ADDR_W]), 64);
    check_eq("R3 clamp to 8",    int'(end_addr[1*ADDR_W +: ADDR_W]), exp_end(1, 12));
    check_eq("R3 three blocks",  int'(end_addr[2*ADDR_W +: ADDR_W]), 320);
    check_eq("R3 wrap ch6",      int'(end_addr[6*ADDR_W +: ADDR_W]), 128);
    check_eq("R3 wrap ch7",      int'(end_addr[7*ADDR_W +: ADDR_W]), 64);
    check_eq("R2 start fixed",   int'(start_addr[6*ADDR_W +: ADDR_W]), 384);
  endtask

  task automatic t_access;
    // ch3: one block, transmit-owned. ch6: four blocks, receive-owned.
    cycle(1, 3, 0, 0, 5, 0);
    check_eq("R4 valid",     int'(rsp_valid), 1);
    check_eq("R4 ok",        int'(rsp_ok), 1);
    check_eq("R4 addr ch3",  int'(rsp_addr), 197);
    check_eq("R6 read no we", int'(ram_we), 0);
    cycle(1, 6, 1, 1, 200, 0);
    check_eq("R4 wrapped addr", int'(rsp_addr), 72);
    check_eq("R6 write we",  int'(ram_we), 1);
    cycle(1, 6, 1, 0, 255, 0);
    check_eq("R4 last word", int'(rsp_addr), 127);
    check_eq("R4 ok last",   int'(rsp_ok), 1);
    cycle(0, 0, 0, 0, 0, 0);
    check_eq("R10 idle valid", int'(rsp_valid), 0);
    check_eq("R10 idle we",    int'(ram_we), 0);
  endtask

  task automatic t_oor;
    cycle(1, 3, 0, 1, 64, 0);
    check_eq("R7 oor flag",  int'(rsp_oor), 1);
    check_eq("R7 not ok",    int'(rsp_ok), 0);
    check_eq("R7 addr zero", int'(rsp_addr), 0);
    check_eq("R7 no we",     int'(ram_we), 0);
    check_eq("R7 no irq",    int'(err_irq), 0);
    cycle(1, 6, 1, 0, 256, 0);
    check_eq("R7 oor ch6",   int'(rsp_oor), 1);
  endtask

  task automatic t_viol;
    cycle(1, 3, 1, 1, 1, 0);
    check_eq("R5 viol flag", int'(rsp_viol), 1);
    check_eq("R5 not ok",    int'(rsp_ok), 0);
    check_eq("R6 blocked we", int'(ram_we), 0);
    check_eq("R9 only bit3", int'(err_irq), 8'h08);
    cycle(1, 6, 0, 0, 2, 0);
    check_eq("R5 tx on rx ch", int'(rsp_viol), 1);
    check_eq("R9 bits 3 and 6", int'(err_irq), 8'h48);
    cycle(0, 0, 0, 0, 0, 0);
    check_eq("R8 held",      int'(err_irq), 8'h48);
    check_eq("R10 viol idle", int'(rsp_viol), 0);
    cycle(0, 0, 0, 0, 0, 8'h08);
    check_eq("R8 cleared",   int'(err_irq), 8'h40);
    cycle(1, 3, 1, 0, 0, 8'h08);
    check_eq("R8 set wins",  int'(err_irq), 8'h48);
    cycle(0, 0, 0, 0, 0, 8'h48);
    check_eq("R8 clear both", int'(err_irq), 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    cfg_size  = '0;
    cfg_owner = 8'h40;
    err_clr   = '0;
    req_valid = 1'b0;
    req_ch    = '0;
    req_rx    = 1'b0;
    req_write = 1'b0;
    req_idx   = '0;
    #(CLK_PERIOD*2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_default_map();
    t_size_cfg();
    t_access();
    t_oor();
    t_viol();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule